// File: doc/BRIEF.md
# Prefix-Directed Register Operand Selector

This block is the operand front end of a small core whose opcodes are one byte wide. Because a byte leaves room to name only one register, the two other operands of an ALU instruction come from a pair of pointers held in the block: a source pointer and a destination pointer. Both point at R0 unless a prefix byte has redirected them. Prefix bytes can retarget the source, the destination, or both. The pointers keep their values across any number of prefixes and fall back to R0 once a non-prefix byte executes.

The block holds sixteen 16-bit registers. R15 is the program counter. It moves forward by one for every byte consumed, unless the executing instruction writes R15, in which case the fetch address takes the written value on the next cycle. A small ALU (add, add-immediate, AND, OR, XOR, move) gives the routing something to carry, and a read port makes any register visible.

Top module: `opsel_core`

## Requirements
- R1: Reset sets all sixteen registers to 0, both pointers to R0, and the fetch address to 0.
- R2: Each cycle with `opValid` high consumes one byte and raises `fetchAddr` (R15) by one, unless that byte writes R15.
- R3: With no prefix pending, `srcSel` and `dstSel` are both 0, and ALU results go to R0 using R0 as the source.
- R4: Byte 0x1n points the source at Rn, 0x2n points the destination at Rn, and 0x3n points both at Rn in the same cycle.
- R5: A prefix that follows another prefix changes only the pointer it targets, and the other pointer keeps its value.
- R6: After any consumed byte whose upper nibble is not 1, 2 or 3, both pointers are 0 on the next cycle.
- R7: Bytes 0x4n, 0x5n, 0x6n and 0x7n write src+Rn, src AND Rn, src OR Rn and src XOR Rn to the destination, and the sum wraps modulo 2^16.
- R8: Byte 0x8n writes src + n (n zero-extended) to the destination.
- R9: Byte 0x9n copies Rn to the destination and ignores the source pointer.
- R10: When an instruction writes R15, `fetchAddr` equals the written value on the next cycle instead of the incremented address.
- R11: While `opValid` is low, no register, pointer or fetch address changes, whatever `opByte` holds.
- R12: Bytes with upper nibble 0x0 or 0xA to 0xF write no register, advance R15, and clear the pointers.
- R13: Reading R15 as an operand yields the address of the byte being executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| opValid | input | 1 | An opcode byte is present this cycle |
| opByte | input | 8 | Opcode byte |
| fetchAddr | output | 16 | Current program counter (R15) |
| srcSel | output | 4 | Current source pointer |
| dstSel | output | 4 | Current destination pointer |
| rdIdx | input | 4 | Register index for the read port |
| rdData | output | 16 | Value of register `rdIdx` |

## Verification
The bench chains two prefixes and then checks that the first pointer survived. A design that cleared on every byte would lose the source choice. The bench also leaves a prefix pending across idle cycles while a stray opcode sits on the bus, which catches a design that samples `opByte` without `opValid`. It writes R15 from both the immediate-add path and the move path, and reads R15 as an operand. A counter that always incremented, or that read the address one byte late, would land on the wrong fetch address. Repeated doubling across the 16-bit limit shows whether the sum wraps. An unassigned opcode issued after a "both" prefix must write nothing, so a decoder that treated it as an ALU op would change R14.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
  localparam int DataW   = 16;
  localparam int NumRegs = 16;
  localparam int OpW     = 8;
  localparam int IdxW    = $clog2(NumRegs);
  localparam int ClsW    = OpW - IdxW;
  localparam int PcIdx   = NumRegs - 1;

  localparam logic [ClsW-1:0] ClsSrc  = ClsW'(1);
  localparam logic [ClsW-1:0] ClsDst  = ClsW'(2);
  localparam logic [ClsW-1:0] ClsBoth = ClsW'(3);
  localparam logic [ClsW-1:0] ClsAdd  = ClsW'(4);
  localparam logic [ClsW-1:0] ClsAnd  = ClsW'(5);
  localparam logic [ClsW-1:0] ClsOr   = ClsW'(6);
  localparam logic [ClsW-1:0] ClsXor  = ClsW'(7);
  localparam logic [ClsW-1:0] ClsAddi = ClsW'(8);
  localparam logic [ClsW-1:0] ClsMov  = ClsW'(9);

  typedef enum logic [2:0] {
    AluAdd, AluAnd, AluOr, AluXor, AluAddi, AluMov
  } aluOp_e;

  typedef struct packed {
    logic            advance;
    logic            wrEn;
    logic [IdxW-1:0] wrIdx;
    logic [IdxW-1:0] srcIdx;
    logic [IdxW-1:0] opdIdx;
    aluOp_e          aluOp;
  } strobes_t;
endpackage

// File: rtl/opsel_ctrl.sv
module opsel_ctrl
  import opsel_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OpW-1:0]  opByte,
  output logic [IdxW-1:0] srcPtr,
  output logic [IdxW-1:0] dstPtr,
  output strobes_t        st
);
  logic [ClsW-1:0] cls;
  logic [IdxW-1:0] field;
  logic [IdxW-1:0] srcNext, dstNext;
  logic            isAluCls;

  assign cls   = opByte[OpW-1:IdxW];
  assign field = opByte[IdxW-1:0];

  always_comb begin
    srcNext = '0;
    dstNext = '0;
    case (cls)
      ClsSrc:  begin srcNext = field;  dstNext = dstPtr; end
      ClsDst:  begin srcNext = srcPtr; dstNext = field;  end
      ClsBoth: begin srcNext = field;  dstNext = field;  end
      default: begin srcNext = '0;     dstNext = '0;     end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr <= '0;
      dstPtr <= '0;
    end else if (opValid) begin
      srcPtr <= srcNext;
      dstPtr <= dstNext;
    end
  end

  always_comb begin
    isAluCls = 1'b1;
    st.aluOp = AluAdd;
    case (cls)
      ClsAdd:  st.aluOp = AluAdd;
      ClsAnd:  st.aluOp = AluAnd;
      ClsOr:   st.aluOp = AluOr;
      ClsXor:  st.aluOp = AluXor;
      ClsAddi: st.aluOp = AluAddi;
      ClsMov:  st.aluOp = AluMov;
      default: isAluCls = 1'b0;
    endcase
    st.advance = opValid;
    st.wrEn    = opValid && isAluCls;
    st.wrIdx   = dstPtr;
    st.srcIdx  = srcPtr;
    st.opdIdx  = field;
  end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_pkg::*;
(
  input  aluOp_e           op,
  input  logic [DataW-1:0] srcVal,
  input  logic [DataW-1:0] opdVal,
  input  logic [IdxW-1:0]  imm,
  output logic [DataW-1:0] result
);
  logic [DataW-1:0] immExt;
  assign immExt = {{(DataW-IdxW){1'b0}}, imm};

  always_comb begin
    case (op)
      AluAdd:  result = srcVal + opdVal;
      AluAnd:  result = srcVal & opdVal;
      AluOr:   result = srcVal | opdVal;
      AluXor:  result = srcVal ^ opdVal;
      AluAddi: result = srcVal + immExt;
      AluMov:  result = opdVal;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/opsel_dpath.sv
module opsel_dpath
  import opsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         st,
  input  logic [IdxW-1:0]  rdIdx,
  output logic [DataW-1:0] rdData,
  output logic [DataW-1:0] pcVal
);
  logic [DataW-1:0] regs [NumRegs];
  logic [DataW-1:0] srcVal, opdVal, aluRes;

  assign srcVal = regs[st.srcIdx];
  assign opdVal = regs[st.opdIdx];
  assign rdData = regs[rdIdx];
  assign pcVal  = regs[PcIdx];

  opsel_alu u_alu (
    .op     (st.aluOp),
    .srcVal (srcVal),
    .opdVal (opdVal),
    .imm    (st.opdIdx),
    .result (aluRes)
  );

  for (genvar i = 0; i < NumRegs; i++) begin : g_reg
    localparam logic [IdxW-1:0] MyIdx = IdxW'(i);
    logic [DataW-1:0] q;
    logic             hit;
    assign hit     = st.wrEn && (st.wrIdx == MyIdx);
    assign regs[i] = q;
    if (i == PcIdx) begin : g_pc
      always_ff @(posedge clk) begin
        if (!rstN)           q <= '0;
        else if (st.advance) q <= hit ? aluRes : q + DataW'(1);
      end
    end else begin : g_gpr
      always_ff @(posedge clk) begin
        if (!rstN)   q <= '0;
        else if (hit) q <= aluRes;
      end
    end
  end
endmodule

// File: rtl/opsel_core.sv
module opsel_core
  import opsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OpW-1:0]   opByte,
  output logic [DataW-1:0] fetchAddr,
  output logic [IdxW-1:0]  srcSel,
  output logic [IdxW-1:0]  dstSel,
  input  logic [IdxW-1:0]  rdIdx,
  output logic [DataW-1:0] rdData
);
  strobes_t st;

  opsel_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opByte  (opByte),
    .srcPtr  (srcSel),
    .dstPtr  (dstSel),
    .st      (st)
  );

  opsel_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .rdIdx  (rdIdx),
    .rdData (rdData),
    .pcVal  (fetchAddr)
  );
endmodule

// File: rtl/opsel_checker.sv
module opsel_checker
  import opsel_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [OpW-1:0]   opByte,
  input logic [DataW-1:0] fetchAddr,
  input logic [IdxW-1:0]  srcSel,
  input logic [IdxW-1:0]  dstSel
);
  logic [ClsW-1:0] cls;
  logic            isPrefix, writesAlu, writesPc;
  assign cls       = opByte[OpW-1:IdxW];
  assign isPrefix  = (cls == ClsSrc) || (cls == ClsDst) || (cls == ClsBoth);
  assign writesAlu = (cls >= ClsAdd) && (cls <= ClsMov);
  assign writesPc  = writesAlu && (dstSel == IdxW'(PcIdx));

  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (fetchAddr == '0 && srcSel == '0 && dstSel == '0));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !writesPc) |=> fetchAddr == $past(fetchAddr) + DataW'(1));

  p_both_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && cls == ClsBoth) |=> (srcSel == $past(opByte[IdxW-1:0]) && dstSel == $past(opByte[IdxW-1:0])));

  p_src_keeps_dst_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && cls == ClsSrc) |=> (srcSel == $past(opByte[IdxW-1:0]) && $stable(dstSel)));

  p_dst_keeps_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && cls == ClsDst) |=> (dstSel == $past(opByte[IdxW-1:0]) && $stable(srcSel)));

  p_clear_after_use_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !isPrefix) |=> (srcSel == '0 && dstSel == '0));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(fetchAddr) && $stable(srcSel) && $stable(dstSel)));
endmodule

bind opsel_core opsel_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opByte    (opByte),
  .fetchAddr (fetchAddr),
  .srcSel    (srcSel),
  .dstSel    (dstSel)
);

// File: tb/opsel_core_tb_top.sv
module opsel_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opByte = 8'h00;
  logic [15:0] fetchAddr;
  logic [3:0]  srcSel, dstSel;
  logic [3:0]  rdIdx = 4'd0;
  logic [15:0] rdData;
  int checks = 0;
  int errors = 0;
  logic [15:0] expPc = 16'd0;
  logic [15:0] savedPc;

  always #5 clk = ~clk;

  opsel_core dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte),
    .fetchAddr(fetchAddr), .srcSel(srcSel), .dstSel(dstSel),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] b);
    opValid = 1'b1;
    opByte  = b;
    @(posedge clk);
    #1;
    opValid = 1'b0;
    expPc = expPc + 16'd1;
  endtask

  task automatic readReg(input logic [3:0] idx, output logic [15:0] v);
    rdIdx = idx;
    #1;
    v = rdData;
  endtask

  task automatic checkReg(input string req, input logic [3:0] idx, input logic [15:0] exp);
    logic [15:0] v;
    readReg(idx, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    check("R1 fetchAddr", fetchAddr, 16'd0);
    check("R1 srcSel", {12'd0, srcSel}, 16'd0);
    check("R1 dstSel", {12'd0, dstSel}, 16'd0);
    for (int i = 0; i < 16; i++) checkReg("R1 register", 4'(i), 16'd0);
  endtask

  task automatic t_default;
    issue(8'h85);
    checkReg("R3 default R0+5", 4'd0, 16'd5);
    check("R2 pc step", fetchAddr, expPc);
    issue(8'h83);
    checkReg("R8 R0 addi", 4'd0, 16'd8);
    check("R3 srcSel default", {12'd0, srcSel}, 16'd0);
  endtask

  task automatic t_dst_prefix;
    issue(8'h21);
    check("R4 dst prefix dstSel", {12'd0, dstSel}, 16'd1);
    check("R4 dst prefix srcSel", {12'd0, srcSel}, 16'd0);
    issue(8'h82);
    checkReg("R4 R1=R0+2", 4'd1, 16'd10);
    checkReg("R4 R0 untouched", 4'd0, 16'd8);
    check("R6 pointers clear", {8'd0, srcSel, dstSel}, 16'd0);
  endtask

  task automatic t_both;
    issue(8'h31);
    check("R4 both src", {12'd0, srcSel}, 16'd1);
    check("R4 both dst", {12'd0, dstSel}, 16'd1);
    issue(8'h41);
    checkReg("R7 R1=R1+R1", 4'd1, 16'd20);
  endtask

  task automatic t_chain;
    issue(8'h22); issue(8'h8F);
    checkReg("R8 R2=R0+15", 4'd2, 16'd23);
    issue(8'h12); issue(8'h23);
    check("R5 chained src kept", {12'd0, srcSel}, 16'd2);
    check("R5 chained dst", {12'd0, dstSel}, 16'd3);
    issue(8'h41);
    checkReg("R5 R3=R2+R1", 4'd3, 16'd43);
  endtask

  task automatic t_logic;
    issue(8'h12); issue(8'h24); issue(8'h51);
    checkReg("R7 and", 4'd4, 16'd20);
    issue(8'h25); issue(8'h12); issue(8'h61);
    checkReg("R7 or", 4'd5, 16'd23);
    issue(8'h12); issue(8'h26); issue(8'h71);
    checkReg("R7 xor", 4'd6, 16'd3);
  endtask

  task automatic t_mov_wrap;
    issue(8'h12); issue(8'h27); issue(8'h93);
    checkReg("R9 mov ignores src", 4'd7, 16'd43);
    issue(8'h29); issue(8'h81);
    for (int i = 0; i < 13; i++) begin
      issue(8'h39); issue(8'h49);
    end
    checkReg("R7 add wraps", 4'd9, 16'h2000);
  endtask

  task automatic t_pc;
    savedPc = expPc + 16'd1;
    issue(8'h2A); issue(8'h9F);
    checkReg("R13 R15 read as operand", 4'd10, savedPc);
    issue(8'h2F); issue(8'h84);
    expPc = 16'd12;
    check("R10 pc write addi", fetchAddr, 16'd12);
    issue(8'h80);
    check("R2 step after redirect", fetchAddr, 16'd13);
    issue(8'h2F); issue(8'h93);
    expPc = 16'd43;
    check("R10 pc write mov", fetchAddr, 16'd43);
  endtask

  task automatic t_idle;
    issue(8'h1C);
    opByte = 8'h85;
    repeat (3) @(posedge clk);
    #1;
    check("R11 src held", {12'd0, srcSel}, 16'd12);
    check("R11 pc held", fetchAddr, expPc);
    checkReg("R11 R0 unchanged", 4'd0, 16'd8);
    issue(8'h00);
  endtask

  task automatic t_unassigned;
    issue(8'h3E); issue(8'hA7);
    checkReg("R12 R14 not written", 4'd14, 16'd0);
    checkReg("R12 R7 unchanged", 4'd7, 16'd43);
    check("R12 pointers cleared", {8'd0, srcSel, dstSel}, 16'd0);
    check("R12 pc advanced", fetchAddr, expPc);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rstN = 1'b1;
    t_default;
    t_dst_prefix;
    t_both;
    t_chain;
    t_logic;
    t_mov_wrap;
    t_pc;
    t_idle;
    t_unassigned;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule